// File: doc/BRIEF.md
# Byte-Wide Hardware Stack Controller

This block owns a 16-bit stack pointer over a byte-addressed, single-port synchronous memory. A client issues push and pull requests for single bytes or 16-bit words, plus call and return requests that save or restore a 16-bit return address. The controller sequences the byte transfers on the memory port and moves the pointer by one per byte. It returns pulled data on a response channel.

The pointer always addresses the next free byte. A byte push writes at the pointer and then decrements it. A word push writes its low byte at the pointer and its high byte one address below, so a stored word has its most significant byte at the lower address. A pull increments the pointer first and then reads. A word pull therefore fetches the high byte first. All pointer arithmetic wraps modulo 2^16 with no error indication.

Requests use a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a transfer is in progress, while a pulled value waits on the response channel, and during any cycle in which a pointer load is requested. The response channel is also valid/ready. A response stays presented, with its data frozen, until `rsp_ready` is seen high on a clock edge. The memory reads with one cycle of latency.

Top module: `byte_stack_ctrl`

## Requirements
- R1: After reset the pointer equals parameter RESET_SP (default 0x00FF), `rsp_valid` is low and `req_ready` is high.
- R2: Op code 0 (byte push) performs one memory write of `req_data[7:0]` at the current pointer, and the pointer then decreases by 1.
- R3: Op codes 1 (word push) and 4 (call) each perform two writes: `req_data[7:0]` at pointer P, then `req_data[15:8]` at P-1. The pointer ends at P-2.
- R4: Op code 2 (byte pull) reads address P+1 and leaves the pointer at P+1. The response data is that byte zero-extended to 16 bits.
- R5: Op codes 3 (word pull) and 5 (return) read P+1 as the high byte and then P+2 as the low byte. The pointer ends at P+2 and the response data is {high, low}.
- R6: `rsp_ret` is high with a response exactly when the response comes from op code 5.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response and its data hold steady, and no new request is accepted.
- R8: When `sp_load` is high while the controller is idle, `req_ready` is low in that cycle and the pointer equals `sp_load_val` after the next clock edge.
- R9: Pointer arithmetic wraps: a push at 0x0000 continues at 0xFFFF, and a pull at 0xFFFF continues at 0x0000.
- R10: Op codes 6 and 7 are accepted and ignored. They cause no memory access and leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Operation code (see R2 to R5, R10) |
| req_data | input | 16 | Value to push (byte pushes use bits 7:0) |
| rsp_valid | output | 1 | Pulled value present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_data | output | 16 | Pulled value |
| rsp_ret | output | 1 | Response belongs to a return |
| sp_load | input | 1 | Load the pointer (effective when idle) |
| sp_load_val | input | 16 | Value for the pointer load |
| sp | output | 16 | Current stack pointer |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read |

## Verification
The assertions assume three things about the environment. The memory returns read data exactly one cycle after a read access. `sp_load` is never raised in the same cycle as a request that the client expects to be taken. Nothing other than the controller drives the pointer. The bench meets all three. It models the memory with a fixed one-cycle read. It applies pointer loads only between requests, with `req_valid` low. It holds `req_valid` until the handshake completes and drops it right after. Random back-pressure of zero to three cycles on `rsp_ready` exercises the response hold.

// File: rtl/byte_stack_pkg.sv
package byte_stack_pkg;
  localparam logic [2:0] OP_PUSH_B = 3'd0;
  localparam logic [2:0] OP_PUSH_W = 3'd1;
  localparam logic [2:0] OP_PULL_B = 3'd2;
  localparam logic [2:0] OP_PULL_W = 3'd3;
  localparam logic [2:0] OP_CALL   = 3'd4;
  localparam logic [2:0] OP_RET    = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_RD_HI,
    ST_RD_LAST,
    ST_RSP
  } seq_state_e;
endpackage

// File: rtl/byte_stack_ptr.sv
module byte_stack_ptr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_SP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          dn,
  input  logic          up,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)  ptr <= RESET_SP;
    else if (ld) ptr <= ld_val;
    else if (dn) ptr <= ptr - ONE;
    else if (up) ptr <= ptr + ONE;
  end

  // R8: a load never coincides with a pointer step
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld, dn, up}));
endmodule

// File: rtl/byte_stack_rsp.sv
module byte_stack_rsp #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_ret,
  input  logic            cap_hi,
  input  logic            cap_lo,
  input  logic [BW-1:0]   rdata,
  output logic [2*BW-1:0] data,
  output logic            is_ret
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data   <= '0;
      is_ret <= 1'b0;
    end else if (start) begin
      data   <= '0;
      is_ret <= start_ret;
    end else begin
      if (cap_hi) data[2*BW-1:BW] <= rdata;
      if (cap_lo) data[BW-1:0]    <= rdata;
    end
  end

  // R5: high and low halves are never captured in the same cycle
  p_cap_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_hi && cap_lo));
endmodule

// File: rtl/byte_stack_seq.sv
module byte_stack_seq
  import byte_stack_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [2*BW-1:0] req_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  input  logic            sp_load,
  input  logic [AW-1:0]   ptr,
  output logic            ptr_ld,
  output logic            ptr_dn,
  output logic            ptr_up,
  output logic            rsp_start,
  output logic            rsp_start_ret,
  output logic            cap_hi,
  output logic            cap_lo,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata
);
  localparam logic [AW-1:0] ONE = AW'(1);

  seq_state_e    state, state_nx;
  logic [BW-1:0] hi_q;
  logic          take;

  assign take = req_valid && req_ready;

  always_comb begin
    state_nx      = state;
    req_ready     = 1'b0;
    rsp_valid     = 1'b0;
    ptr_ld        = 1'b0;
    ptr_dn        = 1'b0;
    ptr_up        = 1'b0;
    rsp_start     = 1'b0;
    rsp_start_ret = 1'b0;
    cap_hi        = 1'b0;
    cap_lo        = 1'b0;
    mem_en        = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = ptr;
    mem_wdata     = '0;
    case (state)
      ST_IDLE: begin
        req_ready = !sp_load;
        ptr_ld    = sp_load;
        if (take) begin
          case (req_op)
            OP_PUSH_B, OP_PUSH_W, OP_CALL: begin
              mem_en    = 1'b1;
              mem_we    = 1'b1;
              mem_wdata = req_data[BW-1:0];
              ptr_dn    = 1'b1;
              if (req_op != OP_PUSH_B) state_nx = ST_WR_HI;
            end
            OP_PULL_B, OP_PULL_W, OP_RET: begin
              mem_en        = 1'b1;
              mem_addr      = ptr + ONE;
              ptr_up        = 1'b1;
              rsp_start     = 1'b1;
              rsp_start_ret = (req_op == OP_RET);
              state_nx      = (req_op == OP_PULL_B) ? ST_RD_LAST : ST_RD_HI;
            end
            default: ;
          endcase
        end
      end
      ST_WR_HI: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = hi_q;
        ptr_dn    = 1'b1;
        state_nx  = ST_IDLE;
      end
      ST_RD_HI: begin
        cap_hi   = 1'b1;
        mem_en   = 1'b1;
        mem_addr = ptr + ONE;
        ptr_up   = 1'b1;
        state_nx = ST_RD_LAST;
      end
      ST_RD_LAST: begin
        cap_lo   = 1'b1;
        state_nx = ST_RSP;
      end
      ST_RSP: begin
        rsp_valid = 1'b1;
        if (rsp_ready) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hi_q  <= '0;
    end else begin
      state <= state_nx;
      if (take) hi_q <= req_data[2*BW-1:BW];
    end
  end

  // R7: a stalled response stays presented
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid);
  // R7: no request is taken while a response is pending
  p_no_take_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R8: a load request blocks acceptance
  p_load_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> !req_ready);
endmodule

// File: rtl/byte_stack_ctrl.sv
module byte_stack_ctrl #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter logic [AW-1:0] RESET_SP = 16'h00FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [2*BW-1:0] req_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [2*BW-1:0] rsp_data,
  output logic            rsp_ret,
  input  logic            sp_load,
  input  logic [AW-1:0]   sp_load_val,
  output logic [AW-1:0]   sp,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata
);
  logic ptr_ld, ptr_dn, ptr_up;
  logic rsp_start, rsp_start_ret, cap_hi, cap_lo;

  byte_stack_ptr #(.AW(AW), .RESET_SP(RESET_SP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .ld_val(sp_load_val),
    .dn(ptr_dn), .up(ptr_up), .ptr(sp)
  );

  byte_stack_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .sp_load(sp_load), .ptr(sp), .ptr_ld(ptr_ld),
    .ptr_dn(ptr_dn), .ptr_up(ptr_up), .rsp_start(rsp_start),
    .rsp_start_ret(rsp_start_ret), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  byte_stack_rsp #(.BW(BW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .start(rsp_start), .start_ret(rsp_start_ret),
    .cap_hi(cap_hi), .cap_lo(cap_lo), .rdata(mem_rdata),
    .data(rsp_data), .is_ret(rsp_ret)
  );

  // R2: every write lands at the pointer, which then steps down by one
  p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we |=> sp == AW'($past(mem_addr) - AW'(1)));
  // R4: every read address becomes the new pointer
  p_rd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && !mem_we |=> sp == $past(mem_addr));
  // R7: data of a stalled response does not change
  p_rsp_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> $stable(rsp_data) && $stable(rsp_ret));
endmodule

// File: tb/byte_stack_ctrl_tb.sv
module byte_stack_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [15:0] req_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic        rsp_ret;
  logic        sp_load = 1'b0;
  logic [15:0] sp_load_val = '0;
  logic [15:0] sp;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int n_acc = 0;
  logic [7:0]  tmem [256];
  logic [7:0]  rmem [256];
  logic [15:0] rsp_m;

  always #4 clk = ~clk;

  byte_stack_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_ret(rsp_ret),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .sp(sp),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      n_acc <= n_acc + 1;
      if (mem_we) tmem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= tmem[mem_addr[7:0]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_pull(input logic [2:0] op);
    return op == 3'd2 || op == 3'd3 || op == 3'd5;
  endfunction

  // model: pointer movement of a legal op
  function automatic logic [15:0] exp_sp(input logic [2:0] op, input logic [15:0] p);
    case (op)
      3'd0: return p - 16'd1;
      3'd1, 3'd4: return p - 16'd2;
      3'd2: return p + 16'd1;
      3'd3, 3'd5: return p + 16'd2;
      default: return p;
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [15:0] d, input string tag);
    logic [15:0] p0, e;
    int hold;
    int acc0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d;
    while (!req_ready) @(negedge clk);
    p0 = sp;
    acc0 = n_acc;
    @(negedge clk);
    req_valid = 1'b0;
    case (op)
      3'd0: rmem[p0[7:0]] = d[7:0];
      3'd1, 3'd4: begin
        rmem[p0[7:0]] = d[7:0];
        rmem[8'(p0[7:0] - 8'd1)] = d[15:8];
      end
      default: ;
    endcase
    if (is_pull(op)) begin
      if (op == 3'd2) e = {8'h00, rmem[8'(p0[7:0] + 8'd1)]};
      else e = {rmem[8'(p0[7:0] + 8'd1)], rmem[8'(p0[7:0] + 8'd2)]};
      while (!rsp_valid) @(negedge clk);
      chk(rsp_data == e, {tag, " data"}, 32'(rsp_data), 32'(e));
      chk(rsp_ret == (op == 3'd5), "R6 ret flag", 32'(rsp_ret), 32'(op == 3'd5));
      hold = int'($urandom % 4);
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == e && !req_ready, "R7 hold",
            32'(rsp_data), 32'(e));
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end
    while (!req_ready) @(negedge clk);
    chk(sp == exp_sp(op, p0), {tag, " sp"}, 32'(sp), 32'(exp_sp(op, p0)));
    if (op == 3'd1 || op == 3'd4)
      chk(tmem[p0[7:0]] == d[7:0] && tmem[8'(p0[7:0] - 8'd1)] == d[15:8],
          "R3 byte order", {16'h0, tmem[p0[7:0]], tmem[8'(p0[7:0] - 8'd1)]},
          {16'h0, d[7:0], d[15:8]});
    if (op == 3'd0)
      chk(tmem[p0[7:0]] == d[7:0], "R2 byte written", 32'(tmem[p0[7:0]]), 32'(d[7:0]));
    if (op >= 3'd6)
      chk(n_acc == acc0, "R10 no access", n_acc, acc0);
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = v;
    #1;
    chk(!req_ready, "R8 ready low on load", 32'(req_ready), 0);
    @(negedge clk);
    sp_load = 1'b0;
    chk(sp == v, "R8 loaded", 32'(sp), 32'(v));
  endtask

  initial begin
    logic [2:0] op;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      tmem[i] = 8'h00;
      rmem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 16'h00FF, "R1 reset sp", 32'(sp), 32'h00FF);
    chk(!rsp_valid && req_ready, "R1 reset flags", {30'h0, rsp_valid, req_ready}, 32'h1);

    run_op(3'd0, 16'h00A5, "R2 push byte");
    run_op(3'd1, 16'h1234, "R3 push word");
    run_op(3'd4, 16'hBEEF, "R3 call");
    run_op(3'd5, 16'h0000, "R5 return");
    run_op(3'd3, 16'h0000, "R5 pull word");
    run_op(3'd2, 16'h0000, "R4 pull byte");
    run_op(3'd6, 16'hFFFF, "R10 reserved 6");
    run_op(3'd7, 16'hFFFF, "R10 reserved 7");

    load_sp(16'h0000);
    run_op(3'd0, 16'h005A, "R9 push wrap");
    load_sp(16'h0000);
    run_op(3'd1, 16'hC3D4, "R9 word push wrap");
    run_op(3'd3, 16'h0000, "R9 word pull wrap");
    chk(sp == 16'h0000, "R9 back to zero", 32'(sp), 0);

    load_sp(16'h0080);
    for (int k = 0; k < 300; k++) begin
      op = 3'($urandom % 8);
      run_op(op, 16'($urandom), "R2-mix random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule